// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block hides fetch latency after a taken branch on a pipeline that has no branch prediction. It is looked up only when a branch has actually been taken. Each entry holds a short run of sequential instructions that begin at a branch target address. On a hit, the block streams the cached run out, one instruction per cycle, starting in the cycle after the branch. In that first cycle it also gives the address just past the cached run, so the fetch unit can start refetching from memory there while the cached instructions execute.

On a miss, the block claims the entry that the target maps to. It then records the next instructions that the fetch path delivers for that target, and it marks the entry valid once the whole run has arrived. A second taken branch before the run is complete abandons the fill and leaves the entry invalid. A single invalidate input empties the whole cache.

The cache is direct-mapped. The default build holds 32 entries of four 32-bit instructions, which is 512 bytes. A 2-instruction, 128-entry build (1024 bytes) is obtained by parameter.

Top module: `branch_target_icache`

## Requirements
- R1: During and after reset every entry is invalid, and `insn_valid_o` and `resume_valid_o` are low until a taken branch hits.
- R2: A taken branch that hits makes `insn_valid_o` high for exactly RUN_LEN consecutive cycles, starting in the cycle after `br_taken_i`. In those cycles `insn_o` gives the cached instructions for target, target+4, target+8, … in that order.
- R3: `resume_valid_o` is high only in the first cycle of a hit run. In that cycle `resume_addr_o` equals the branch target plus 4·RUN_LEN.
- R4: A taken branch that misses produces neither `insn_valid_o` nor `resume_valid_o`. The next RUN_LEN cycles that have `fill_valid_i` high (counted from the cycle after the branch) supply the entry's instructions in address order, and the entry is valid for later branches to the same target.
- R5: The entry index is target bits [IDX_W+1:2], with IDX_W = log2(ENTRIES). The tag is the bits above the index. A filled target with the same index and a different tag evicts the earlier target, which then misses.
- R6: A taken branch that arrives while a fill is still incomplete abandons the fill. This includes a branch in the same cycle as the last fill word. The abandoned entry stays invalid, and the new branch is looked up normally.
- R7: `inval_i` clears every valid bit at the next clock edge. It also stops a fill in progress without validating that fill. A branch in the same cycle as `inval_i` is treated as a miss.
- R8: A taken branch during a hit run ends that run at once. The following cycle issues the new target's result.
- R9: `fill_valid_i` words that arrive while no fill is pending are ignored and leave cached contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_taken_i | input | 1 | A branch was taken this cycle |
| br_target_i | input | ADDR_W | Byte address of the branch target |
| fill_valid_i | input | 1 | Fetch path delivers one instruction this cycle |
| fill_insn_i | input | INSN_W | Instruction delivered by the fetch path |
| inval_i | input | 1 | Clear all entries |
| insn_valid_o | output | 1 | `insn_o` carries a cached instruction |
| insn_o | output | INSN_W | Cached instruction being issued |
| resume_valid_o | output | 1 | First cycle of a hit run; `resume_addr_o` is valid |
| resume_addr_o | output | ADDR_W | Address at which memory fetch should resume |

## Verification
The bench builds the block with ENTRIES=4, RUN_LEN=2 and ADDR_W=16. With that build, three tags swept across every index give each entry its cold miss, its hit and its conflict eviction within a few hundred cycles. Every slot of every run is compared with an instruction value computed from the target address. The small run length lets the bench line up exactly the hard cycles: a branch on the final fill word, an invalidate combined with a pending fill word, and a redirect in the middle of a run.

// File: rtl/btc_pkg.sv
package btc_pkg;

    localparam int WORD_BYTES = 4;
    localparam int OFS_W      = 2;

    typedef enum logic [1:0] {
        BTC_IDLE  = 2'd0,
        BTC_ISSUE = 2'd1,
        BTC_FILL  = 2'd2
    } btc_state_e;

    // Per-cycle commands from the controller to the storage arrays.
    typedef struct packed {
        logic clr_valid;   // drop the entry claimed by a miss
        logic set_valid;   // entry completed, mark valid with tag
        logic wr_data;     // write one fill word
    } btc_cmd_t;

    function automatic int run_bytes(input int run_len);
        return run_len * WORD_BYTES;
    endfunction

    function automatic int slot_width(input int run_len);
        return (run_len > 1) ? $clog2(run_len) : 1;
    endfunction

endpackage

// File: rtl/btc_tag_store.sv
module btc_tag_store #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5,
    parameter int TAG_W   = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inval,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             clr_en,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (inval) begin
            valid_q <= '0;
        end else begin
            if (clr_en) valid_q[lk_idx]  <= 1'b0;
            if (set_en) valid_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_q[set_idx] <= set_tag;
    end

    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/btc_data_store.sv
module btc_data_store #(
    parameter int ENTRIES = 32,
    parameter int RUN_LEN = 4,
    parameter int INSN_W  = 32,
    parameter int IDX_W   = 5,
    parameter int SLOT_W  = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [INSN_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [INSN_W-1:0] rd_data
);

    logic [INSN_W-1:0] bank_out [RUN_LEN];

    // One bank per position within a run.
    for (genvar b = 0; b < RUN_LEN; b++) begin : g_bank
        logic [INSN_W-1:0] mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == SLOT_W'(b))) mem[wr_idx] <= wr_data;
        end

        assign bank_out[b] = mem[rd_idx];
    end

    always_comb begin
        rd_data = bank_out[0];
        for (int b = 1; b < RUN_LEN; b++) begin
            if (rd_slot == SLOT_W'(b)) rd_data = bank_out[b];
        end
    end

endmodule

// File: rtl/btc_ctrl.sv
module btc_ctrl
    import btc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RUN_LEN = 4,
    parameter int IDX_W   = 5,
    parameter int TAG_W   = 25,
    parameter int SLOT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              hit,
    input  logic              inval,
    input  logic              fill_valid,
    output btc_state_e        state,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [TAG_W-1:0]  cur_tag,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [ADDR_W-1:0] resume_addr,
    output btc_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(run_bytes(RUN_LEN));
    localparam logic [SLOT_W-1:0] LAST     = SLOT_W'(RUN_LEN - 1);

    btc_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ADDR_W-1:0] resume_q;
    logic              fill_step;

    assign fill_step = (state_q == BTC_FILL) && !br_taken && !inval && fill_valid;

    always_comb begin
        cmd           = '0;
        cmd.clr_valid = br_taken && !hit;
        cmd.wr_data   = fill_step;
        cmd.set_valid = fill_step && (slot_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BTC_IDLE;
            idx_q    <= '0;
            tag_q    <= '0;
            slot_q   <= '0;
            resume_q <= '0;
        end else if (br_taken) begin
            idx_q  <= br_target[IDX_W+OFS_W-1:OFS_W];
            tag_q  <= br_target[ADDR_W-1:IDX_W+OFS_W];
            slot_q <= '0;
            if (hit) begin
                state_q  <= BTC_ISSUE;
                resume_q <= br_target + STEP;
            end else begin
                state_q  <= BTC_FILL;
            end
        end else begin
            unique case (state_q)
                BTC_ISSUE: begin
                    if (slot_q == LAST) state_q <= BTC_IDLE;
                    else                slot_q  <= slot_q + 1'b1;
                end
                BTC_FILL: begin
                    if (inval) begin
                        state_q <= BTC_IDLE;
                    end else if (fill_valid) begin
                        if (slot_q == LAST) state_q <= BTC_IDLE;
                        else                slot_q  <= slot_q + 1'b1;
                    end
                end
                default: state_q <= BTC_IDLE;
            endcase
        end
    end

    assign state       = state_q;
    assign cur_idx     = idx_q;
    assign cur_tag     = tag_q;
    assign cur_slot    = slot_q;
    assign resume_addr = resume_q;

endmodule

// File: rtl/branch_target_icache.sv
module branch_target_icache
    import btc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int INSN_W  = 32,
    parameter int ENTRIES = 32,
    parameter int RUN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_taken_i,
    input  logic [ADDR_W-1:0] br_target_i,
    input  logic              fill_valid_i,
    input  logic [INSN_W-1:0] fill_insn_i,
    input  logic              inval_i,
    output logic              insn_valid_o,
    output logic [INSN_W-1:0] insn_o,
    output logic              resume_valid_o,
    output logic [ADDR_W-1:0] resume_addr_o
);

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
    localparam int SLOT_W = slot_width(RUN_LEN);

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic              hit;
    btc_state_e        state;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [SLOT_W-1:0] cur_slot;
    btc_cmd_t          cmd;

    assign lk_idx = br_target_i[IDX_W+OFS_W-1:OFS_W];
    assign lk_tag = br_target_i[ADDR_W-1:IDX_W+OFS_W];
    assign hit    = lk_hit && !inval_i;

    btc_tag_store #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .inval   (inval_i),
        .lk_idx  (lk_idx),
        .lk_tag  (lk_tag),
        .lk_hit  (lk_hit),
        .clr_en  (cmd.clr_valid),
        .set_en  (cmd.set_valid),
        .set_idx (cur_idx),
        .set_tag (cur_tag)
    );

    btc_data_store #(
        .ENTRIES (ENTRIES),
        .RUN_LEN (RUN_LEN),
        .INSN_W  (INSN_W),
        .IDX_W   (IDX_W),
        .SLOT_W  (SLOT_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (cmd.wr_data),
        .wr_idx  (cur_idx),
        .wr_slot (cur_slot),
        .wr_data (fill_insn_i),
        .rd_idx  (cur_idx),
        .rd_slot (cur_slot),
        .rd_data (insn_o)
    );

    btc_ctrl #(
        .ADDR_W  (ADDR_W),
        .RUN_LEN (RUN_LEN),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .SLOT_W  (SLOT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .br_taken    (br_taken_i),
        .br_target   (br_target_i),
        .hit         (hit),
        .inval       (inval_i),
        .fill_valid  (fill_valid_i),
        .state       (state),
        .cur_idx     (cur_idx),
        .cur_tag     (cur_tag),
        .cur_slot    (cur_slot),
        .resume_addr (resume_addr_o),
        .cmd         (cmd)
    );

    assign insn_valid_o   = (state == BTC_ISSUE);
    assign resume_valid_o = (state == BTC_ISSUE) && (cur_slot == '0);

endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
    parameter int ADDR_W  = 32,
    parameter int RUN_LEN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              br_taken_i,
    input logic [ADDR_W-1:0] br_target_i,
    input logic              inval_i,
    input logic              insn_valid_o,
    input logic              resume_valid_o,
    input logic [ADDR_W-1:0] resume_addr_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(RUN_LEN * 4);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!insn_valid_o && !resume_valid_o));

    p_resume_in_run_r3: assert property (@(posedge clk) disable iff (rst)
        resume_valid_o |-> insn_valid_o);

    p_resume_after_branch_r3: assert property (@(posedge clk) disable iff (rst)
        resume_valid_o |-> $past(br_taken_i));

    p_resume_addr_r3: assert property (@(posedge clk) disable iff (rst)
        resume_valid_o |-> (resume_addr_o == $past(br_target_i) + STEP));

    p_run_contiguous_r2: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_o && !resume_valid_o) |-> $past(insn_valid_o));

    p_miss_silent_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(br_taken_i) && !resume_valid_o) |-> !insn_valid_o);

    p_inval_forces_miss_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(br_taken_i) && $past(inval_i)) |-> !resume_valid_o);

endmodule

bind branch_target_icache btc_checker #(
    .ADDR_W  (ADDR_W),
    .RUN_LEN (RUN_LEN)
) u_btc_checker (
    .clk            (clk),
    .rst            (rst),
    .br_taken_i     (br_taken_i),
    .br_target_i    (br_target_i),
    .inval_i        (inval_i),
    .insn_valid_o   (insn_valid_o),
    .resume_valid_o (resume_valid_o),
    .resume_addr_o  (resume_addr_o)
);

// File: tb/tb_branch_target_icache.sv
module tb_branch_target_icache;

    localparam int AW   = 16;
    localparam int IW   = 32;
    localparam int NE   = 4;
    localparam int RL   = 2;
    localparam int IDXW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          br_taken_i = 1'b0;
    logic [AW-1:0] br_target_i = '0;
    logic          fill_valid_i = 1'b0;
    logic [IW-1:0] fill_insn_i = '0;
    logic          inval_i = 1'b0;
    logic          insn_valid_o;
    logic [IW-1:0] insn_o;
    logic          resume_valid_o;
    logic [AW-1:0] resume_addr_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    bit            mv [NE];
    logic [AW-1:0] ma [NE];

    always #5 clk = ~clk;

    branch_target_icache #(
        .ADDR_W  (AW),
        .INSN_W  (IW),
        .ENTRIES (NE),
        .RUN_LEN (RL)
    ) dut (
        .clk            (clk),
        .rst            (rst),
        .br_taken_i     (br_taken_i),
        .br_target_i    (br_target_i),
        .fill_valid_i   (fill_valid_i),
        .fill_insn_i    (fill_insn_i),
        .inval_i        (inval_i),
        .insn_valid_o   (insn_valid_o),
        .insn_o         (insn_o),
        .resume_valid_o (resume_valid_o),
        .resume_addr_o  (resume_addr_o)
    );

    function automatic logic [IW-1:0] word_of(input logic [AW-1:0] a, input int k);
        return (32'(a) * 32'h9E3779B1) + (32'(k) * 32'h01010101) + 32'h5A;
    endfunction

    function automatic int idx_of(input logic [AW-1:0] a);
        return int'(a[IDXW+1:2]);
    endfunction

    function automatic logic [AW-1:0] addr_of(input int tag, input int idx);
        return AW'((tag << (IDXW + 2)) | (idx << 2));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_branch(input logic [AW-1:0] a);
        @(negedge clk);
        br_taken_i  = 1'b1;
        br_target_i = a;
        @(negedge clk);
        br_taken_i  = 1'b0;
    endtask

    // Called in the first cycle after the branch edge.
    task automatic expect_run(input logic [AW-1:0] a, input string req);
        chk({req, " R3 resume_valid"}, 32'(resume_valid_o), 32'd1);
        chk({req, " R3 resume_addr"}, 32'(resume_addr_o), 32'(a + AW'(RL * 4)));
        chk({req, " R2 valid slot0"}, 32'(insn_valid_o), 32'd1);
        chk({req, " R2 insn slot0"}, insn_o, word_of(a, 0));
        for (int k = 1; k < RL; k++) begin
            @(negedge clk);
            chk({req, " R2 valid slot"}, 32'(insn_valid_o), 32'd1);
            chk({req, " R3 resume low"}, 32'(resume_valid_o), 32'd0);
            chk({req, " R2 insn slot"}, insn_o, word_of(a, k));
        end
        @(negedge clk);
        chk({req, " R2 run ends"}, 32'(insn_valid_o), 32'd0);
    endtask

    task automatic expect_miss(input string req);
        chk({req, " miss no insn"}, 32'(insn_valid_o), 32'd0);
        chk({req, " miss no resume"}, 32'(resume_valid_o), 32'd0);
    endtask

    task automatic feed(input logic [AW-1:0] a, input int first, input int count);
        for (int k = first; k < first + count; k++) begin
            fill_valid_i = 1'b1;
            fill_insn_i  = word_of(a, k);
            @(negedge clk);
        end
        fill_valid_i = 1'b0;
    endtask

    task automatic visit(input logic [AW-1:0] a, input string req);
        int i;
        i = idx_of(a);
        pulse_branch(a);
        if (mv[i] && ma[i] == a) begin
            expect_run(a, req);
        end else begin
            expect_miss(req);
            feed(a, 0, RL);
            mv[i] = 1'b1;
            ma[i] = a;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        logic [AW-1:0] a, b, x, y;
        for (int i = 0; i < NE; i++) begin
            mv[i] = 1'b0;
            ma[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset insn_valid", 32'(insn_valid_o), 32'd0);
        chk("R1 reset resume_valid", 32'(resume_valid_o), 32'd0);
        rst = 1'b0;

        // R1: cache empty after reset, first lookup misses
        pulse_branch(addr_of(1, 0));
        expect_miss("R1 cold");
        feed(addr_of(1, 0), 0, RL);
        mv[0] = 1'b1;
        ma[0] = addr_of(1, 0);

        // R4, R2, R5: sweep tags across all indexes
        for (int t = 1; t <= 3; t++) begin
            for (int i = 0; i < NE; i++) begin
                visit(addr_of(t, i), "R4 fill");
                visit(addr_of(t, i), "R2 hit");
            end
        end
        for (int i = 0; i < NE; i++) begin
            pulse_branch(addr_of(2, i));
            expect_miss("R5 evicted");
            feed(addr_of(2, i), 0, RL);
            mv[i] = 1'b1;
            ma[i] = addr_of(2, i);
            visit(addr_of(2, i), "R5 refill hit");
        end

        // R9: stray fill words while idle
        for (int k = 0; k < 3; k++) begin
            fill_valid_i = 1'b1;
            fill_insn_i  = 32'hDEAD0000 + 32'(k);
            @(negedge clk);
        end
        fill_valid_i = 1'b0;
        for (int i = 0; i < NE; i++) visit(addr_of(2, i), "R9 unchanged");

        // R6: branch during partial fill
        a = addr_of(5, 1);
        pulse_branch(a);
        expect_miss("R6 first");
        mv[1] = 1'b0;
        feed(a, 0, 1);
        pulse_branch(a);
        expect_miss("R6 abandoned");
        feed(a, 0, RL);
        mv[1] = 1'b1;
        ma[1] = a;
        visit(a, "R6 after refill");

        // R6: branch in the cycle of the last fill word
        b = addr_of(6, 3);
        pulse_branch(b);
        expect_miss("R6 second");
        feed(b, 0, RL - 1);
        br_taken_i   = 1'b1;
        br_target_i  = b;
        fill_valid_i = 1'b1;
        fill_insn_i  = word_of(b, RL - 1);
        @(negedge clk);
        br_taken_i   = 1'b0;
        fill_valid_i = 1'b0;
        expect_miss("R6 last word lost");
        feed(b, 0, RL);
        mv[3] = 1'b1;
        ma[3] = b;
        visit(b, "R6 last word refill");

        // R8: redirect during a run
        x = addr_of(2, 0);
        y = addr_of(2, 2);
        pulse_branch(x);
        chk("R8 first run start", insn_o, word_of(x, 0));
        br_taken_i  = 1'b1;
        br_target_i = y;
        @(negedge clk);
        br_taken_i  = 1'b0;
        expect_run(y, "R8 redirected");

        // R7: global invalidate
        @(negedge clk);
        inval_i = 1'b1;
        @(negedge clk);
        inval_i = 1'b0;
        for (int i = 0; i < NE; i++) mv[i] = 1'b0;
        for (int i = 0; i < NE; i++) begin
            pulse_branch(addr_of(2, i));
            expect_miss("R7 cleared");
            feed(addr_of(2, i), 0, RL);
            mv[i] = 1'b1;
            ma[i] = addr_of(2, i);
        end

        // R7: invalidate during a fill, with a fill word in the same cycle
        a = addr_of(7, 1);
        pulse_branch(a);
        expect_miss("R7 fill start");
        feed(a, 0, 1);
        inval_i      = 1'b1;
        fill_valid_i = 1'b1;
        fill_insn_i  = word_of(a, 1);
        @(negedge clk);
        inval_i      = 1'b0;
        fill_valid_i = 1'b0;
        for (int i = 0; i < NE; i++) mv[i] = 1'b0;
        pulse_branch(a);
        expect_miss("R7 fill stopped");
        feed(a, 0, RL);
        mv[1] = 1'b1;
        ma[1] = a;
        visit(a, "R7 refill hit");

        // R7: invalidate in the same cycle as a branch that would hit
        @(negedge clk);
        br_taken_i  = 1'b1;
        br_target_i = a;
        inval_i     = 1'b1;
        @(negedge clk);
        br_taken_i  = 1'b0;
        inval_i     = 1'b0;
        expect_miss("R7 same-cycle branch");
        for (int i = 0; i < NE; i++) mv[i] = 1'b0;
        feed(a, 0, RL);
        mv[1] = 1'b1;
        ma[1] = a;
        visit(a, "R7 after same-cycle");
        visit(addr_of(2, 0), "R7 other entry gone");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule